// File: doc/BRIEF.md
# LED Driver Standby and Auto-Restart Sequencer

This block supervises the switching stage of an LED driver controller. It watches five comparator flags that are computed elsewhere: two for the dimming input, against a low "go dark" level and a higher "wake" level; one for supply over-voltage; one for over-current, already blanked; and one for over-temperature, already hysteretic. From these flags it decides whether the power switch may run, whether the controller should drop into a low-power standby state, and when the external switching timer must start a fresh soft start.

A low dimming level stops switching straight away. If the level stays low for a qualification delay, the block declares standby. Any protection flag stops switching and starts a common restart wait of about one second. When that wait ends, the block looks at the temperature flag again. It restarts only if the temperature flag is clear; otherwise it waits another full period. Every return to switching is marked by a one-cycle soft-start request.

Both delays are set in milliseconds and converted to clock cycles through a clock-rate parameter.

Top module: `lsq_top`

## Requirements
- R1: While reset is high, `sw_en`, `standby_lp` and `ss_req` are all 0. On the first clock edge after reset falls, `sw_en` goes to 1 and `ss_req` pulses for exactly one cycle.
- R2: While switching, a high `dim_lo` clears `sw_en` at the next clock edge, and `standby_lp` stays 0.
- R3: If `dim_lo` stays high for STBY_MS*CLK_KHZ consecutive cycles after switching stopped, `standby_lp` rises on that edge and not one cycle earlier. `sw_en` stays 0 throughout.
- R4: In standby, a high `dim_hi` clears `standby_lp` and sets `sw_en` with an `ss_req` pulse at the next edge. While both `dim_lo` and `dim_hi` are 0, standby is held.
- R5: During the qualification delay, a high `dim_hi` resumes switching with an `ss_req` pulse. A cycle with `dim_lo` at 0 restarts the delay count from zero.
- R6: A high `ovp_trip` or `ocp_trip` clears `sw_en` at the next edge. Switching resumes, with an `ss_req` pulse, exactly WAIT_MS*CLK_KHZ cycles after that edge if no further fault is seen.
- R7: Either `ovp_trip` or `ocp_trip` seen during the restart wait starts the full wait again from that edge.
- R8: `hot_trip` stops switching like any other fault, but it is only sampled at the end of a wait. If it is still 1 at that point, another full wait follows. Switching restarts at the first wait end that finds it at 0.
- R9: Faults take priority over the dimming flags. A fault during qualification or standby clears `standby_lp` and starts the restart wait. The restart after that wait enters switching with an `ss_req` pulse, whatever the dimming level.
- R10: `sw_en` and `standby_lp` are never 1 together. `ss_req` never stays high for two consecutive cycles.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dim_lo | input | 1 | Dimming input below the standby-enable level |
| dim_hi | input | 1 | Dimming input above the standby-release level |
| ovp_trip | input | 1 | Supply over-voltage flag |
| ocp_trip | input | 1 | Over-current flag, already blanked |
| hot_trip | input | 1 | Over-temperature flag with hysteresis |
| sw_en | output | 1 | Power switching permitted |
| standby_lp | output | 1 | Low-power standby indication |
| ss_req | output | 1 | One-cycle soft-start request to the switching timer |

## Verification
The dimming flags are driven in four patterns:
- a steady low level, which tells a premature standby apart from a correct one;
- a dip into the band between the two levels, which shows whether the qualification count is cleared;
- a release during qualification;
- a release from standby.

The fault flags are driven in four patterns:
- a single over-current or over-voltage pulse, which measures the exact wait length;
- a second pulse inside the wait, which separates a reloaded timer from a free-running one;
- a temperature flag held across one wait end, which shows the re-check at the wait end;
- a fault raised from standby, which proves that faults take priority over dimming.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_RUN   = 3'd1,
    ST_QUAL  = 3'd2,
    ST_STBY  = 3'd3,
    ST_WAIT  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/lsq_cycle_timer.sv
// Saturating up-counter; done while the count sits at its limit.
module lsq_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr && !done) |=> (cnt == $past(cnt) + 1'b1)); // R3
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0)); // R7
endmodule

// File: rtl/lsq_fault_merge.sv
// Splits protection flags into those that reload the wait and the full set.
module lsq_fault_merge (
  input  logic ovp_trip,
  input  logic ocp_trip,
  input  logic hot_trip,
  output logic hard_fault,
  output logic any_fault
);
  assign hard_fault = ovp_trip | ocp_trip;
  assign any_fault  = hard_fault | hot_trip;
endmodule

// File: rtl/lsq_top.sv
module lsq_top #(
  parameter int CLK_KHZ = 1000,
  parameter int STBY_MS = 10,
  parameter int WAIT_MS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic dim_lo,
  input  logic dim_hi,
  input  logic ovp_trip,
  input  logic ocp_trip,
  input  logic hot_trip,
  output logic sw_en,
  output logic standby_lp,
  output logic ss_req
);
  import lsq_pkg::*;

  localparam int STBY_CYC = CLK_KHZ * STBY_MS;
  localparam int WAIT_CYC = CLK_KHZ * WAIT_MS;

  seq_state_t state, nxt;
  logic hard_fault, any_fault;
  logic sb_clr, sb_done, w_clr, w_done, w_reload;

  lsq_fault_merge u_merge (
    .ovp_trip   (ovp_trip),
    .ocp_trip   (ocp_trip),
    .hot_trip   (hot_trip),
    .hard_fault (hard_fault),
    .any_fault  (any_fault)
  );

  assign sb_clr = (state != ST_QUAL) || !dim_lo;

  lsq_cycle_timer #(.LIMIT(STBY_CYC)) u_sb_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (sb_clr),
    .done (sb_done)
  );

  assign w_reload = hard_fault || (w_done && hot_trip);
  assign w_clr    = (state != ST_WAIT) || w_reload;

  lsq_cycle_timer #(.LIMIT(WAIT_CYC)) u_wait_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (w_clr),
    .done (w_done)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_START: nxt = any_fault ? ST_WAIT : ST_RUN;
      ST_RUN: begin
        if (any_fault)   nxt = ST_WAIT;
        else if (dim_lo) nxt = ST_QUAL;
      end
      ST_QUAL: begin
        if (any_fault)              nxt = ST_WAIT;
        else if (dim_hi)            nxt = ST_RUN;
        else if (sb_done && dim_lo) nxt = ST_STBY;
      end
      ST_STBY: begin
        if (any_fault)   nxt = ST_WAIT;
        else if (dim_hi) nxt = ST_RUN;
      end
      ST_WAIT: begin
        if (hard_fault)  nxt = ST_WAIT;
        else if (w_done) nxt = hot_trip ? ST_WAIT : ST_RUN;
      end
      default: nxt = ST_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_START;
      sw_en      <= 1'b0;
      standby_lp <= 1'b0;
      ss_req     <= 1'b0;
    end else begin
      state      <= nxt;
      sw_en      <= (nxt == ST_RUN);
      standby_lp <= (nxt == ST_STBY);
      ss_req     <= (nxt == ST_RUN) && (state != ST_RUN);
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(sw_en && standby_lp)); // R10
  AST_SS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ss_req |=> !ss_req); // R10
  AST_SS_WITH_EN: assert property (@(posedge clk) disable iff (rst)
    ss_req |-> sw_en); // R1
  AST_DIM_STOP: assert property (@(posedge clk) disable iff (rst)
    (sw_en && dim_lo) |=> !sw_en); // R2
  AST_LP_FROM_QUAL: assert property (@(posedge clk) disable iff (rst)
    $rose(standby_lp) |-> $past(state == ST_QUAL)); // R3
  AST_WAKE: assert property (@(posedge clk) disable iff (rst)
    (standby_lp && dim_hi && !any_fault) |=> (sw_en && ss_req)); // R4
  AST_FAULT_STOP: assert property (@(posedge clk) disable iff (rst)
    any_fault |=> (!sw_en && !standby_lp)); // R6
  AST_HOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && hot_trip) |=> !sw_en); // R8
endmodule

// File: tb/lsq_top_bench.sv
module lsq_top_bench;
  localparam int PER = 10;
  localparam int NSB = 8;
  localparam int NW  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dim_lo = 1'b0, dim_hi = 1'b1;
  logic ovp_trip = 1'b0, ocp_trip = 1'b0, hot_trip = 1'b0;
  logic sw_en, standby_lp, ss_req;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(PER/2) clk = ~clk;

  lsq_top #(.CLK_KHZ(1), .STBY_MS(NSB), .WAIT_MS(NW)) u_lsq_top (
    .clk(clk), .rst(rst), .dim_lo(dim_lo), .dim_hi(dim_hi),
    .ovp_trip(ovp_trip), .ocp_trip(ocp_trip), .hot_trip(hot_trip),
    .sw_en(sw_en), .standby_lp(standby_lp), .ss_req(ss_req)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: %s act=%0b exp=%0b", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    cyc(3);
    chk("R1", "sw_en in reset", sw_en, 1'b0);
    chk("R1", "standby_lp in reset", standby_lp, 1'b0);
    chk("R1", "ss_req in reset", ss_req, 1'b0);
    rst = 1'b0;
    cyc(1);
    chk("R1", "sw_en after reset", sw_en, 1'b1);
    chk("R1", "ss_req after reset", ss_req, 1'b1);
    cyc(1);
    chk("R1", "ss_req single", ss_req, 1'b0);
  endtask

  task automatic t_standby;
    dim_lo = 1'b1; dim_hi = 1'b0;
    cyc(1);
    chk("R2", "sw_en off on low dim", sw_en, 1'b0);
    chk("R2", "no lp yet", standby_lp, 1'b0);
    cyc(NSB - 1);
    chk("R3", "lp one cycle early", standby_lp, 1'b0);
    cyc(1);
    chk("R3", "lp at delay", standby_lp, 1'b1);
    chk("R3", "sw_en in standby", sw_en, 1'b0);
    dim_lo = 1'b0;
    cyc(5);
    chk("R4", "lp held in band", standby_lp, 1'b1);
    dim_hi = 1'b1;
    cyc(1);
    chk("R4", "lp cleared", standby_lp, 1'b0);
    chk("R4", "sw_en on wake", sw_en, 1'b1);
    chk("R4", "ss_req on wake", ss_req, 1'b1);
    cyc(1);
  endtask

  task automatic t_qual;
    dim_lo = 1'b1; dim_hi = 1'b0;
    cyc(NSB - 2);
    dim_lo = 1'b0;
    cyc(3);
    chk("R5", "no lp after band dip", standby_lp, 1'b0);
    dim_lo = 1'b1;
    cyc(NSB - 1);
    chk("R5", "count restarted", standby_lp, 1'b0);
    cyc(1);
    chk("R5", "lp after fresh count", standby_lp, 1'b1);
    dim_lo = 1'b0; dim_hi = 1'b1;
    cyc(2);
    dim_lo = 1'b1; dim_hi = 1'b0;
    cyc(2);
    dim_lo = 1'b0; dim_hi = 1'b1;
    cyc(1);
    chk("R5", "resume from qual sw_en", sw_en, 1'b1);
    chk("R5", "resume from qual ss_req", ss_req, 1'b1);
    chk("R5", "resume from qual lp", standby_lp, 1'b0);
    cyc(1);
  endtask

  task automatic t_ocp;
    ocp_trip = 1'b1;
    cyc(1);
    ocp_trip = 1'b0;
    chk("R6", "ocp stops switching", sw_en, 1'b0);
    cyc(NW - 1);
    chk("R6", "still waiting", sw_en, 1'b0);
    cyc(1);
    chk("R6", "restart sw_en", sw_en, 1'b1);
    chk("R6", "restart ss_req", ss_req, 1'b1);
    cyc(1);
  endtask

  task automatic t_retrigger;
    ovp_trip = 1'b1;
    cyc(1);
    ovp_trip = 1'b0;
    cyc(10);
    ovp_trip = 1'b1;
    cyc(1);
    ovp_trip = 1'b0;
    cyc(NW - 1);
    chk("R7", "wait reloaded", sw_en, 1'b0);
    cyc(1);
    chk("R7", "restart after reload", sw_en, 1'b1);
    chk("R7", "ss_req after reload", ss_req, 1'b1);
    cyc(1);
  endtask

  task automatic t_hot;
    hot_trip = 1'b1;
    cyc(1);
    chk("R8", "hot stops switching", sw_en, 1'b0);
    cyc(NW);
    chk("R8", "hot still set at wait end", sw_en, 1'b0);
    cyc(5);
    hot_trip = 1'b0;
    cyc(NW - 6);
    chk("R8", "second wait not done", sw_en, 1'b0);
    cyc(1);
    chk("R8", "restart after cool", sw_en, 1'b1);
    chk("R8", "ss_req after cool", ss_req, 1'b1);
    cyc(1);
  endtask

  task automatic t_fault_standby;
    dim_lo = 1'b1; dim_hi = 1'b0;
    cyc(NSB + 1);
    chk("R9", "in standby first", standby_lp, 1'b1);
    ocp_trip = 1'b1;
    cyc(1);
    ocp_trip = 1'b0;
    chk("R9", "fault clears lp", standby_lp, 1'b0);
    chk("R9", "fault keeps sw off", sw_en, 1'b0);
    cyc(NW - 1);
    chk("R9", "waiting after standby fault", sw_en, 1'b0);
    cyc(1);
    chk("R9", "restart into run", sw_en, 1'b1);
    chk("R9", "restart ss_req", ss_req, 1'b1);
    chk("R10", "ss with no lp", standby_lp, 1'b0);
    cyc(1);
    chk("R10", "ss_req not held", ss_req, 1'b0);
    chk("R2", "low dim stops again", sw_en, 1'b0);
    dim_lo = 1'b0; dim_hi = 1'b1;
    cyc(2);
  endtask

  initial begin
    t_reset();
    t_standby();
    t_qual();
    t_ocp();
    t_retrigger();
    t_hot();
    t_fault_standby();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PER * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule